// File: doc/BRIEF.md
# Two-Wire Settings Slave with Command Decode

This block is a synchronous slave on a two-wire serial bus (I2C-style). It holds one 8-bit settings register that feeds a 5-bit DAC code and three digital output bits. SCL and SDA are oversampled by the system clock through two-flop synchronizers. START, repeated START and STOP are found on the synchronized samples. The slave drives SDA only through an active-high pull-low enable that is meant for an open-drain pad.

A transaction begins with an address byte. Its upper seven bits must equal the slave address, and its LSB selects the direction. After a write-direction address, the master sends a command byte:
- The write command (AAh) arms the slave to accept one data byte. That byte is loaded into the register once its acknowledge clock ends.
- The read command (00h) arms a read. The master then issues a repeated START and the address with the read bit set. The slave returns the register MSB first, once per byte, for as long as the master acknowledges.

The block has no data stream of its own, so its register outputs are plain pins with no valid/ready handshake. No back-pressure exists because the master paces every bit with SCL. Clock stretching, general-call addressing and 10-bit addressing are not provided.

Top module: `twc_slave`

## Requirements
- R1: While reset is asserted and after reset is released, `sda_pull_o` is 0 and the register is 00h (`dac_code_o`=0, `dig_out_o`=0).
- R2: An address byte of 58h (write) or 59h (read) matches the slave address 0101100, and the slave acknowledges it by pulling SDA low during the 9th clock. Any other address byte is not acknowledged, and the slave ignores the bus until the next START or STOP.
- R3: After the write command AAh is acknowledged, the next byte is acknowledged and loaded into the register. Register bits [4:0] drive `dac_code_o` and bits [7:5] drive `dig_out_o`.
- R4: The register changes only at the SCL falling edge that ends the acknowledge clock of an accepted data byte. It keeps its value at all other times.
- R5: A command byte other than AAh or 00h is not acknowledged. Bytes that follow it, up to the next START or STOP, are not acknowledged and leave the register unchanged.
- R6: The read command 00h is acknowledged. After a repeated START and the read address 59h, the slave acknowledges and returns the register MSB first. Each bit is placed after an SCL falling edge and is stable while SCL is high.
- R7: A read address that is not preceded, since the last STOP, by an accepted 00h command is not acknowledged.
- R8: If the master acknowledges (SDA low on the 9th clock) a byte the slave sent, the slave sends the register again. If the master does not acknowledge, the slave releases SDA and ignores the bus until the next START or STOP.
- R9: A STOP at any bit position ends the transfer, discards a partial byte, releases SDA and clears a pending read arm.
- R10: A START received at any bit position restarts address reception and releases SDA.
- R11: `sda_pull_o` changes only on a synchronized SCL falling edge, or when it is released on START or STOP. It never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA pad |
| dac_code_o | output | 5 | Settings register bits [4:0], the DAC code |
| dig_out_o | output | 3 | Settings register bits [7:5], the digital outputs |

## Verification
A wrong phase in the byte state machine shows up at SDA within one bit time. It appears either as a missing or misplaced acknowledge on the 9th clock, or as a data bit that differs at the next SCL high phase. A corrupted shift register or arm flag appears at the register pins. The register must match the master's view from three system clocks after the acknowledge clock ends, so the bench compares it on every clock. A stale arm flag shows up as a wrong acknowledge on the next read address. Aborted bytes, through STOP or repeated START mid-byte, are exercised so that any leaked partial state would change the register or the next acknowledge.

// File: rtl/twc_pkg.sv
package twc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } twc_state_e;

  // Synchronized bus levels and the events derived from them.
  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } twc_ev_t;

endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/twc_events.sv
module twc_events
  import twc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output twc_ev_t ev_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.scl      = scl_i;
    ev_o.sda      = sda_i;
    ev_o.scl_rise = scl_i & ~scl_q;
    ev_o.scl_fall = ~scl_i & scl_q;
    ev_o.start    = scl_i & scl_q & sda_q & ~sda_i;
    ev_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
  end

endmodule

// File: rtl/twc_engine.sv
module twc_engine
  import twc_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-2:0] SLV_ADDR = 7'b0101100,
  parameter logic [DATA_W-1:0] CMD_WR   = 8'hAA,
  parameter logic [DATA_W-1:0] CMD_RD   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  twc_ev_t           ev_i,
  output logic              pull_o,
  output logic [DATA_W-1:0] cfg_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  twc_state_e        state_q, next_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q, cfg_q;
  logic              pull_q, armed_q, wr_pend_q, mack_q;

  logic byte_done, addr_hit, addr_ok;
  assign byte_done = ev_i.scl_fall && (cnt_q == FULL);
  assign addr_hit  = (rx_q[DATA_W-1:1] == SLV_ADDR);
  assign addr_ok   = addr_hit && (!rx_q[0] || armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      next_q    <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      cfg_q     <= '0;
      pull_q    <= 1'b0;
      armed_q   <= 1'b0;
      wr_pend_q <= 1'b0;
      mack_q    <= 1'b1;
    end else if (ev_i.start) begin
      state_q   <= ST_ADDR;
      cnt_q     <= '0;
      pull_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (ev_i.stop) begin
      state_q   <= ST_IDLE;
      pull_q    <= 1'b0;
      armed_q   <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (ev_i.scl_rise && cnt_q != FULL) begin
            rx_q  <= {rx_q[DATA_W-2:0], ev_i.sda};
            cnt_q <= cnt_q + CNT_W'(1);
          end
          if (byte_done) begin
            state_q <= ST_IGNORE;
            if (state_q == ST_ADDR) begin
              if (addr_ok) begin
                pull_q  <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= rx_q[0] ? ST_RD_BYTE : ST_CMD;
              end
            end else if (state_q == ST_CMD) begin
              if (rx_q == CMD_WR) begin
                pull_q  <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= ST_WDATA;
              end else if (rx_q == CMD_RD) begin
                pull_q  <= 1'b1;
                armed_q <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= ST_IGNORE;
              end
            end else begin
              pull_q    <= 1'b1;
              wr_pend_q <= 1'b1;
              state_q   <= ST_ACK;
              next_q    <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (ev_i.scl_fall) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= next_q;
            if (wr_pend_q) begin
              cfg_q     <= rx_q;
              wr_pend_q <= 1'b0;
            end
            if (next_q == ST_RD_BYTE) begin
              pull_q <= ~cfg_q[DATA_W-1];
              tx_q   <= {cfg_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_RD_BYTE: begin
          if (ev_i.scl_fall) begin
            if (cnt_q == LAST) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RD_ACK;
            end else begin
              pull_q <= ~tx_q[DATA_W-1];
              tx_q   <= {tx_q[DATA_W-2:0], 1'b1};
              cnt_q  <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RD_ACK: begin
          if (ev_i.scl_rise) mack_q <= ev_i.sda;
          if (ev_i.scl_fall) begin
            if (!mack_q) begin
              state_q <= ST_RD_BYTE;
              pull_q  <= ~cfg_q[DATA_W-1];
              tx_q    <= {cfg_q[DATA_W-2:0], 1'b1};
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign pull_o = pull_q;
  assign cfg_o  = cfg_q;

endmodule

// File: rtl/twc_slave.sv
module twc_slave
  import twc_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'b0101100,
  parameter logic [7:0] CMD_WR      = 8'hAA,
  parameter logic [7:0] CMD_RD      = 8'h00,
  parameter int         DAC_W       = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [7-DAC_W:0] dig_out_o
);

  localparam int DATA_W = 8;

  logic [1:0]        line_s;
  twc_ev_t           ev;
  logic [DATA_W-1:0] cfg;

  twc_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (line_s)
  );

  twc_events u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (line_s[1]),
    .sda_i (line_s[0]),
    .ev_o  (ev)
  );

  twc_engine #(
    .DATA_W   (DATA_W),
    .SLV_ADDR (SLV_ADDR),
    .CMD_WR   (CMD_WR),
    .CMD_RD   (CMD_RD)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev),
    .pull_o (sda_pull_o),
    .cfg_o  (cfg)
  );

  assign dac_code_o = cfg[DAC_W-1:0];
  assign dig_out_o  = cfg[DATA_W-1:DAC_W];

endmodule

// File: rtl/twc_slave_chk.sv
module twc_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       pull,
  input logic [7:0] reg_v
);

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !pull);

  assert_release_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !pull);

  assert_pull_moves_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> $past(scl_fall || start_ev || stop_ev));

  assert_pull_still_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(pull));

  assert_reg_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_v) |-> $past(scl_fall));

endmodule

bind twc_slave twc_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (ev.scl),
  .scl_fall (ev.scl_fall),
  .start_ev (ev.start),
  .stop_ev  (ev.stop),
  .pull     (sda_pull_o),
  .reg_v    ({dig_out_o, dac_code_o})
);

// File: tb/sim_twc_slave.sv
`timescale 1ns/1ps
module sim_twc_slave;

  localparam int Q = 6;
  localparam logic [7:0] AW = 8'h58;
  localparam logic [7:0] AR = 8'h59;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic pull;
  logic [4:0] dac;
  logic [2:0] dig;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int skip = 0;
  int exp_reg = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~pull;

  twc_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (pull),
    .dac_code_o (dac),
    .dig_out_o  (dig)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Register model compared on every clock (R4).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (skip > 0) skip--;
      else chk({dig, dac} == exp_reg[7:0], "R4 register vs model", {dig, dac}, exp_reg);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
    wq();
  endtask

  task automatic bit_xfer(input bit b, input bit upd, input logic [7:0] nv, output bit r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_bus; wq();
    if (upd) begin
      exp_reg = nv;
      skip = 8;
    end
    scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, input bit upd, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], 1'b0, 8'h00, r);
    bit_xfer(1'b1, upd, b, ack);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, 1'b0, 8'h00, r);
      d[i] = r;
    end
    bit_xfer(mack, 1'b0, 8'h00, r);
  endtask

  initial begin
    bit a0, a1, a2, r;
    logic [7:0] d;

    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R1 pull in reset", pull, 0);
    chk({dig, dac} == 8'h00, "R1 register in reset", {dig, dac}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R1 pull after reset", pull, 0);

    // Plain write of B5h.
    bus_start();
    write_byte(AW, 1'b0, a0);
    chk(a0 == 1'b0, "R2 write address ack", a0, 0);
    write_byte(8'hAA, 1'b0, a1);
    chk(a1 == 1'b0, "R3 write command ack", a1, 0);
    write_byte(8'hB5, 1'b1, a2);
    chk(a2 == 1'b0, "R3 data byte ack", a2, 0);
    bus_stop();
    chk(dac == 5'h15, "R3 dac field", dac, 5'h15);
    chk(dig == 3'h5, "R3 digital field", dig, 3'h5);

    // Wrong address, then a byte that must be ignored.
    bus_start();
    write_byte(8'h5A, 1'b0, a0);
    chk(a0 == 1'b1, "R2 wrong address nack", a0, 1);
    write_byte(8'hAA, 1'b0, a1);
    chk(a1 == 1'b1, "R2 ignored after mismatch", a1, 1);
    bus_stop();

    // Bad command.
    bus_start();
    write_byte(AW, 1'b0, a0);
    write_byte(8'h55, 1'b0, a1);
    chk(a1 == 1'b1, "R5 bad command nack", a1, 1);
    write_byte(8'h3C, 1'b0, a2);
    chk(a2 == 1'b1, "R5 following byte nack", a2, 1);
    bus_stop();
    chk({dig, dac} == 8'hB5, "R5 register untouched", {dig, dac}, 8'hB5);

    // Read without arming.
    bus_start();
    write_byte(AR, 1'b0, a0);
    chk(a0 == 1'b1, "R7 unarmed read nack", a0, 1);
    bus_stop();

    // Armed read, two bytes.
    bus_start();
    write_byte(AW, 1'b0, a0);
    write_byte(8'h00, 1'b0, a1);
    chk(a1 == 1'b0, "R6 read command ack", a1, 0);
    bus_start();
    write_byte(AR, 1'b0, a2);
    chk(a2 == 1'b0, "R6 read address ack", a2, 0);
    read_byte(1'b0, d);
    chk(d == 8'hB5, "R6 read data", d, 8'hB5);
    read_byte(1'b1, d);
    chk(d == 8'hB5, "R8 second byte after master ack", d, 8'hB5);
    chk(pull == 1'b0, "R8 released after master nack", pull, 0);
    bit_xfer(1'b1, 1'b0, 8'h00, r);
    chk(r == 1'b1, "R8 bus ignored after master nack", r, 1);
    bus_stop();

    // STOP clears the read arm.
    bus_start();
    write_byte(AR, 1'b0, a0);
    chk(a0 == 1'b1, "R9 arm cleared by stop", a0, 1);
    bus_stop();

    // STOP mid data byte.
    bus_start();
    write_byte(AW, 1'b0, a0);
    write_byte(8'hAA, 1'b0, a1);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, 1'b0, 8'h00, r);
    bus_stop();
    chk({dig, dac} == 8'hB5, "R9 partial byte discarded", {dig, dac}, 8'hB5);
    chk(pull == 1'b0, "R9 released after stop", pull, 0);
    bus_start();
    write_byte(AW, 1'b0, a0);
    write_byte(8'hAA, 1'b0, a1);
    write_byte(8'h4A, 1'b1, a2);
    bus_stop();
    chk({dig, dac} == 8'h4A, "R9 write after abort", {dig, dac}, 8'h4A);

    // Repeated START mid data byte.
    bus_start();
    write_byte(AW, 1'b0, a0);
    write_byte(8'hAA, 1'b0, a1);
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, 1'b0, 8'h00, r);
    bus_start();
    write_byte(AW, 1'b0, a0);
    chk(a0 == 1'b0, "R10 address after repeated start", a0, 0);
    write_byte(8'hAA, 1'b0, a1);
    write_byte(8'h13, 1'b1, a2);
    chk(a2 == 1'b0, "R10 data ack after restart", a2, 0);
    bus_stop();
    chk({dig, dac} == 8'h13, "R10 register after restart", {dig, dac}, 8'h13);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule